// File: doc/BRIEF.md
# Bridge quiesce handshake controller

This block quiesces and releases the ports of an asynchronous interconnect bridge. Each bridge port has a control word whose bit 0 asks the port to stop. The bridge reports back through an acknowledge flag and through empty and full flags. A caller issues one command at a time: a port number together with an enable or disable request. For a disable request the controller sets the port's stop request. For an enable request it clears the stop request. It then watches that port's acknowledge flag and finishes with either a done pulse or a timeout pulse. Port number zero means there is no bridge for the unit, and the command finishes at once.

The port control words, together with a fixed identification word, can also be read and written through a simple register port. A write takes effect only if its top byte holds the password 0x5A. Any write without the password is dropped and sets a sticky error flag. The timeout window is given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `bridge_quiesce_ctrl`

## Requirements
- R1: After reset, every stop request is 0, and `busy`, `done`, `timeout` and `pw_err` are all 0.
- R2: Port n (1..NUM_PORTS) is read at byte address PORT_BASE+4*(n-1), which is 0x08..0x1C by default. Bit 0 of the read word is the port's stop request, bit 1 its acknowledge, bit 2 its empty flag and bit 3 its full flag. All other bits read 0.
- R3: Address PORT_BASE+4*NUM_PORTS (0x20 by default) reads 0x62726467. Any address that is not mapped reads 0.
- R4: A register write with 0x5A in bits 31:24 to a port address loads that port's stop request from bit 0 of the write data. Bits 3:1 cannot be written.
- R5: A register write whose bits 31:24 differ from 0x5A leaves every stop request unchanged. It sets `pw_err`, which stays at 1 until reset.
- R6: An accepted command for a valid port sets that port's stop request when `cmd_enable`=0 and clears it when `cmd_enable`=1. The other ports are unchanged.
- R7: A command with `cmd_sel` equal to 0 or greater than NUM_PORTS raises `done` for one cycle after the accepting edge. It never raises `busy` and changes no register.
- R8: `busy` is 1 from the edge that accepts a command for a valid port until the edge that ends it. A command presented while `busy` is 1 is ignored.
- R9: At the first clock edge after acceptance where the selected port's acknowledge is sampled low, `done` pulses for one cycle and `busy` falls.
- R10: If the acknowledge is sampled high on T consecutive edges, where T = CLK_MHZ*TIMEOUT_NS/1000 (minimum 1), `timeout` pulses for one cycle and `busy` falls. The stop request keeps the value the command wrote.
- R11: `done` and `timeout` are never 1 together. An acknowledge that is low on the T-th edge gives `done`, not `timeout`.
- R12: If a command and a password-correct register write target the same port in the same cycle, the command's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_enable | input | 1 | 1 = release the port (clear stop), 0 = quiesce it (set stop) |
| cmd_sel | input | SEL_W | Port number, 0 = no bridge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data, password in bits 31:24 |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pw_err | output | 1 | Sticky password error |
| br_stop | output | NUM_PORTS | Stop request for each port |
| br_ack | input | NUM_PORTS | Acknowledge from each port |
| br_empty | input | NUM_PORTS | Empty flag from each port |
| br_full | input | NUM_PORTS | Full flag from each port |

## Verification
The bench builds the block with six ports, CLK_MHZ=250 and TIMEOUT_NS=40, which gives a window of ten cycles. With a window that short, a full timeout fits in a few cycles. An acknowledge that drops on the last counted edge, or on the edge just before it, can then be placed exactly. All port addresses and the identification word stay at their default positions, so the address decode is covered at its real boundaries. This includes the first address past the identification word and the invalid port number seven.

// File: rtl/bqh_pkg.sv
package bqh_pkg;
  localparam logic [7:0]  PASSWORD  = 8'h5A;
  localparam logic [31:0] BRIDGE_ID = 32'h6272_6467;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

  // Timeout window in cycles, floor, never below one.
  function automatic int unsigned wait_cycles(input int unsigned clk_mhz,
                                              input int unsigned limit_ns);
    int unsigned c;
    c = (clk_mhz * limit_ns) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Read image of a port control word.
  function automatic logic [31:0] pack_ctl(input logic stop, input logic ack,
                                           input logic empty, input logic full);
    return {28'd0, full, empty, ack, stop};
  endfunction
endpackage

// File: rtl/bqh_portregs.sv
module bqh_portregs
  import bqh_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 8,
  parameter int PORT_BASE = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 cmd_wr,
  input  logic [IDX_W-1:0]     cmd_idx,
  input  logic                 cmd_stop,
  input  logic [NUM_PORTS-1:0] br_ack,
  input  logic [NUM_PORTS-1:0] br_empty,
  input  logic [NUM_PORTS-1:0] br_full,
  output logic [NUM_PORTS-1:0] stop_o,
  output logic                 pw_err_o
);
  localparam int ID_OFF = PORT_BASE + 4 * NUM_PORTS;

  logic             pw_ok;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [NUM_PORTS-1:0] stop_q;

  assign pw_ok = (reg_wdata[31:24] == PASSWORD);

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (reg_addr == ADDR_W'(PORT_BASE + 4 * i)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stop_q[g] <= 1'b0;
      end else if (cmd_wr && cmd_idx == IDX_W'(g)) begin
        stop_q[g] <= cmd_stop;
      end else if (reg_wr && pw_ok && hit && hit_idx == IDX_W'(g)) begin
        stop_q[g] <= reg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_err_o <= 1'b0;
    else if (reg_wr && !pw_ok) pw_err_o <= 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit)
      reg_rdata = pack_ctl(stop_q[hit_idx], br_ack[hit_idx],
                           br_empty[hit_idx], br_full[hit_idx]);
    else if (reg_addr == ADDR_W'(ID_OFF))
      reg_rdata = BRIDGE_ID;
  end

  assign stop_o = stop_q;

  p_pwerr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pw_err_o |=> pw_err_o);
  p_badpw_nochange_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !pw_ok && !cmd_wr) |=> $stable(stop_q));
  p_cmd_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (stop_q[$past(cmd_idx)] == $past(cmd_stop)));
endmodule

// File: rtl/bqh_seq.sv
module bqh_seq
  import bqh_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int SEL_W     = 3,
  parameter int IDX_W     = 3,
  parameter int WAIT_CYC  = 250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_enable,
  input  logic [SEL_W-1:0]     cmd_sel,
  input  logic [NUM_PORTS-1:0] br_ack,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 timeout_o,
  output logic                 wr_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic                 wr_stop_o
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept_ev;
  logic             sel_valid;
  logic             ack_now;
  logic             last_edge;

  assign accept_ev = cmd_valid && (state_q == ST_IDLE);
  assign sel_valid = (cmd_sel != '0) && (int'(cmd_sel) <= NUM_PORTS);
  assign wr_o      = accept_ev && sel_valid;
  assign wr_idx_o  = IDX_W'(cmd_sel - 1'b1);
  assign wr_stop_o = !cmd_enable;
  assign ack_now   = br_ack[idx_q];
  assign last_edge = (cnt_q == CNT_W'(WAIT_CYC - 1));
  assign busy_o    = (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept_ev) begin
          if (sel_valid) begin
            state_q <= ST_WAIT;
            idx_q   <= wr_idx_o;
            cnt_q   <= '0;
          end else begin
            done_o <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (!ack_now) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last_edge) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
  p_end_clears_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !busy_o);
  p_timeout_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $past(busy_o));
  p_no_write_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_o);
endmodule

// File: rtl/bridge_quiesce_ctrl.sv
module bridge_quiesce_ctrl
  import bqh_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int CLK_MHZ    = 250,
  parameter int TIMEOUT_NS = 1000,
  parameter int ADDR_W     = 8,
  parameter int PORT_BASE  = 8,
  localparam int SEL_W     = $clog2(NUM_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_enable,
  input  logic [SEL_W-1:0]     cmd_sel,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 pw_err,
  output logic [NUM_PORTS-1:0] br_stop,
  input  logic [NUM_PORTS-1:0] br_ack,
  input  logic [NUM_PORTS-1:0] br_empty,
  input  logic [NUM_PORTS-1:0] br_full
);
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int WAIT_CYC = int'(wait_cycles(CLK_MHZ, TIMEOUT_NS));

  logic             seq_wr;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_stop;

  bqh_seq #(
    .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .IDX_W(IDX_W), .WAIT_CYC(WAIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_enable(cmd_enable), .cmd_sel(cmd_sel),
    .br_ack(br_ack),
    .busy_o(busy), .done_o(done), .timeout_o(timeout),
    .wr_o(seq_wr), .wr_idx_o(seq_idx), .wr_stop_o(seq_stop)
  );

  bqh_portregs #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cmd_wr(seq_wr), .cmd_idx(seq_idx), .cmd_stop(seq_stop),
    .br_ack(br_ack), .br_empty(br_empty), .br_full(br_full),
    .stop_o(br_stop), .pw_err_o(pw_err)
  );

  // R6: a command to a valid port drives its stop line to the requested value.
  p_cmd_reaches_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_sel != '0 && int'(cmd_sel) <= NUM_PORTS)
      |=> (br_stop[$past(cmd_sel) - 1'b1] == !$past(cmd_enable)));
  // R7: a command with no bridge never starts a wait.
  p_nobridge_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_sel == '0) |=> (done && !busy));
endmodule

// File: tb/bridge_quiesce_ctrl_tb_top.sv
module bridge_quiesce_ctrl_tb_top;
  localparam int NP = 6;
  localparam int T  = 10;   // 250 MHz * 40 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_enable = 1'b0;
  logic [2:0] cmd_sel = '0;
  logic busy, done, timeout, pw_err;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] br_stop;
  logic [NP-1:0] br_ack = '0, br_empty = '0, br_full = '0;

  int checks = 0;
  int errors = 0;
  int seen_done = 0, seen_to = 0;

  always #2 clk = ~clk;

  bridge_quiesce_ctrl #(.NUM_PORTS(NP), .CLK_MHZ(250), .TIMEOUT_NS(40)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_enable(cmd_enable), .cmd_sel(cmd_sel),
    .busy(busy), .done(done), .timeout(timeout),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pw_err(pw_err),
    .br_stop(br_stop), .br_ack(br_ack), .br_empty(br_empty), .br_full(br_full)
  );

  // Behavioural reference state
  bit m_stop[NP];
  bit m_pwerr, m_busy, m_done, m_to;
  int m_idx, m_cnt;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h20) return 32'h6272_6467;
    for (int p = 0; p < NP; p++)
      if (a == 8'(8 + 4 * p))
        return {28'd0, br_full[p], br_empty[p], br_ack[p], m_stop[p]};
    return 32'd0;
  endfunction

  function automatic logic [NP-1:0] m_stopvec();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = m_stop[p];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_stop[p] = 1'b0;
      m_pwerr = 0; m_busy = 0; m_done = 0; m_to = 0; m_idx = 0; m_cnt = 0;
    end else begin
      int wp;
      bit wv;
      wp = -1; wv = 0;
      m_done = 0; m_to = 0;
      if (!m_busy) begin
        if (cmd_valid) begin
          if (cmd_sel >= 1 && cmd_sel <= NP) begin
            wp = int'(cmd_sel) - 1; wv = !cmd_enable;
            m_busy = 1; m_idx = wp; m_cnt = 0;
          end else m_done = 1;
        end
      end else begin
        if (!br_ack[m_idx]) begin m_done = 1; m_busy = 0; end
        else if (m_cnt == T - 1) begin m_to = 1; m_busy = 0; end
        else m_cnt++;
      end
      if (reg_wr) begin
        if (reg_wdata[31:24] == 8'h5A) begin
          for (int p = 0; p < NP; p++)
            if (reg_addr == 8'(8 + 4 * p) && p != wp) m_stop[p] = reg_wdata[0];
        end else m_pwerr = 1;
      end
      if (wp >= 0) m_stop[wp] = wv;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(32'(busy),    32'(m_busy),  "R8 busy");
      chk(32'(done),    32'(m_done),  "R9 done");
      chk(32'(timeout), 32'(m_to),    "R10 timeout");
      chk(32'(pw_err),  32'(m_pwerr), "R5 pw_err");
      chk(32'(br_stop), 32'(m_stopvec()), "R6 stop lines");
      chk(reg_rdata,    m_read(reg_addr), "R2 read data");
      if (done && timeout) chk(1, 0, "R11 both outcomes");
      if (done) seen_done++;
      if (timeout) seen_to++;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [2:0] sel, input logic en);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_enable = en;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(32'(br_stop), 0, "R1 stop after reset");
    chk(32'({busy, done, timeout, pw_err}), 0, "R1 flags after reset");

    // R3 identification and unmapped
    reg_addr = 8'h20; step();
    chk(reg_rdata, 32'h6272_6467, "R3 id word");
    reg_addr = 8'h24; step();
    chk(reg_rdata, 0, "R3 unmapped past id");
    reg_addr = 8'h04; step();
    chk(reg_rdata, 0, "R3 unmapped below ports");

    // R2 status layout on port 3 (0x10)
    br_ack = 6'b000100; br_empty = 6'b000100; br_full = 6'b000000;
    reg_addr = 8'h10; step();
    chk(reg_rdata, 32'h6, "R2 port3 ack+empty");
    br_ack = '0; br_empty = '0; br_full = 6'b100000;
    reg_addr = 8'h1C; step();
    chk(reg_rdata, 32'h8, "R2 port6 full");
    br_full = '0;

    // R4 password write to port 2
    wr(8'h0C, 32'h5A00_0001);
    chk(32'(br_stop), 32'h2, "R4 stop set by write");
    wr(8'h0C, 32'h5A00_000E);
    chk(32'(br_stop), 32'h0, "R4 status bits not writable, stop cleared");

    // R5 bad password
    wr(8'h08, 32'h1200_0001);
    chk(32'(br_stop), 0, "R5 bad write dropped");
    chk(32'(pw_err), 1, "R5 pw_err set");

    // R6/R9 disable port 4 with ack already low
    seen_done = 0;
    issue(3'd4, 1'b0);
    chk(32'(br_stop), 32'h8, "R6 disable sets stop");
    step();
    chk(32'(seen_done), 1, "R9 done with ack low");

    // R9 ack drops after a few cycles on port 5
    br_ack[4] = 1'b1; seen_done = 0;
    issue(3'd5, 1'b0);
    step(); step();
    br_ack[4] = 1'b0;
    step(); step();
    chk(32'(seen_done), 1, "R9 done after ack drop");
    chk(32'(busy), 0, "R9 busy released");

    // R10 timeout on port 1, with R8 ignored command while busy
    br_ack[0] = 1'b1; seen_to = 0;
    issue(3'd1, 1'b0);
    issue(3'd2, 1'b0);
    chk(32'(br_stop[1]), 0, "R8 command while busy ignored");
    repeat (T + 2) step();
    chk(32'(seen_to), 1, "R10 timeout raised");
    chk(32'(br_stop[0]), 1, "R10 stop kept after timeout");
    br_ack[0] = 1'b0;

    // R11 ack low exactly on the T-th edge
    br_ack[5] = 1'b1; seen_done = 0; seen_to = 0;
    issue(3'd6, 1'b0);
    repeat (T - 1) step();
    br_ack[5] = 1'b0;
    repeat (3) step();
    chk(32'(seen_done), 1, "R11 done on last edge");
    chk(32'(seen_to), 0, "R11 no timeout on last edge");

    // R7 no-bridge selects
    seen_done = 0;
    issue(3'd0, 1'b0);
    chk(32'(busy), 0, "R7 sel0 not busy");
    chk(32'(seen_done), 1, "R7 sel0 done");
    issue(3'd7, 1'b0);
    chk(32'(seen_done), 2, "R7 sel7 done");

    // R12 command and same-port write in one cycle
    cmd_valid = 1'b1; cmd_sel = 3'd3; cmd_enable = 1'b0;
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h5A00_0000;
    step();
    cmd_valid = 1'b0; reg_wr = 1'b0;
    chk(32'(br_stop[2]), 1, "R12 command wins");
    step();

    // R6 enable clears
    issue(3'd4, 1'b1);
    chk(32'(br_stop[3]), 0, "R6 enable clears stop");
    repeat (3) step();

    // R5 sticky across activity
    chk(32'(pw_err), 1, "R5 pw_err sticky");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule